// File: doc/BRIEF.md
# Stochastic Mantissa Rounding Stage

This block finishes the narrowing of a floating-point mantissa when the
destination keeps fewer mantissa bits than the source. It receives a value
that has already been truncated to the destination layout (sign, exponent,
mantissa) together with the low source mantissa bits that truncation threw
away and a seed word. It decides whether to bump the mantissa by one unit in
the last place, and it presents the rounded value one clock later.

The decision is probabilistic. The seed is stepped once through a fixed-tap
shift-register function to form a draw. The draw, read as a fraction of the
largest seed word, is set against the discarded bits, read as a fraction of
the all-ones source mantissa. If the discarded fraction is not larger than the
drawn fraction, the value rounds up. Both fractions are compared by integer
cross-multiplication, so no divider appears in the datapath. A round-up that
overflows the mantissa carries into the exponent, except that an all-ones
exponent is left alone.

Top module: `sr_round_stage`

## Requirements
- R1: While reset is asserted and after its release with no strobe yet, `out_valid`, `out_sign`, `out_exp` and `out_mant` are all zero.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high; on cycles with `in_valid` low the result registers keep their previous value.
- R3: The draw is the seed shifted right by one place, ORed with a feedback bit placed at bit position 15, where the feedback bit is the XOR of seed bits 0, 1, 3 and 12.
- R4: The value rounds up exactly when `in_disc * (2^SEED_W - 1) <= draw * (2^SRC_MANT_W - 1)`, with unsigned arithmetic.
- R5: When the value does not round up, the registered exponent and mantissa equal the inputs.
- R6: A round-up on a mantissa that is not all ones adds one to the mantissa and leaves the exponent unchanged.
- R7: A round-up on an all-ones mantissa gives a zero mantissa and an exponent one larger, when the exponent is not all ones.
- R8: A round-up on an all-ones mantissa with an all-ones exponent gives a zero mantissa and keeps the all-ones exponent.
- R9: The sign is carried from input to output unchanged by rounding.
- R10: A zero `in_disc` always rounds up, whatever the seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: the inputs below are sampled on this cycle |
| in_sign | input | 1 | Sign of the truncated value |
| in_exp | input | DST_EXP_W | Exponent of the truncated value |
| in_mant | input | DST_MANT_W | Truncated destination mantissa |
| in_disc | input | SRC_MANT_W-DST_MANT_W | Low source mantissa bits removed by truncation |
| in_seed | input | SEED_W | Seed for the shift-register draw |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_sign | output | 1 | Rounded sign |
| out_exp | output | DST_EXP_W | Rounded exponent |
| out_mant | output | DST_MANT_W | Rounded mantissa |

## Verification
The block holds no state across results other than the output registers, so a
fault in the draw, the comparison or the carry shows up on the very result
produced one cycle after the strobe that exercised it. Seeds are chosen so the
feedback bit alone tips the decision, and discarded values sit one step either
side of the comparison threshold, so an error in a tap, in a product or in the
direction of the comparison flips a single output mantissa bit. Carry
corners (all-ones mantissa, all-ones exponent) and idle cycles between strobes
expose a wrong carry path or a register that loads without a strobe at once.

// File: rtl/sr_round_pkg.sv
package sr_round_pkg;

   // Seed bit positions XORed into the feedback bit.
   localparam int unsigned FB_TAP_A = 0;
   localparam int unsigned FB_TAP_B = 1;
   localparam int unsigned FB_TAP_C = 3;
   localparam int unsigned FB_TAP_D = 12;
   // Bit position of the draw that receives the feedback bit.
   localparam int unsigned FB_INSERT_POS = 15;
   // Smallest seed width that holds every tap and the insert position.
   localparam int unsigned MIN_SEED_W = FB_INSERT_POS + 1;

   // Comparator variants.
   typedef enum logic [0:0] {
      CMP_SHIFT_SUB = 1'b0,   // products of all-ones constants via shift and subtract
      CMP_MULTIPLY  = 1'b1    // generic multiplier operator
   } cmp_style_e;

endpackage

// File: rtl/sr_draw_gen.sv
module sr_draw_gen
   import sr_round_pkg::*;
#(
   parameter int unsigned SEED_W = 32
) (
   input  logic [SEED_W-1:0] seed,
   output logic [SEED_W-1:0] draw
);

   logic fb_bit;
   logic [SEED_W-1:0] fb_word;

   always_comb begin
      fb_bit  = seed[FB_TAP_A] ^ seed[FB_TAP_B] ^ seed[FB_TAP_C] ^ seed[FB_TAP_D];
      fb_word = '0;
      fb_word[FB_INSERT_POS] = fb_bit;
      draw    = (seed >> 1) | fb_word;
   end

endmodule

// File: rtl/sr_frac_cmp.sv
module sr_frac_cmp
   import sr_round_pkg::*;
#(
   parameter int unsigned DISC_W     = 16,
   parameter int unsigned SRC_MANT_W = 23,
   parameter int unsigned SEED_W     = 32,
   parameter cmp_style_e  CMP_STYLE  = CMP_SHIFT_SUB
) (
   input  logic [DISC_W-1:0] disc,
   input  logic [SEED_W-1:0] draw,
   output logic              take_up
);

   // Product width: draw * (2^SRC_MANT_W - 1) is the wider of the two sides.
   localparam int unsigned PW = SEED_W + SRC_MANT_W;

   logic [PW-1:0] disc_ext;
   logic [PW-1:0] draw_ext;
   logic [PW-1:0] lhs;
   logic [PW-1:0] rhs;

   assign disc_ext = PW'(disc);
   assign draw_ext = PW'(draw);

   generate
      if (CMP_STYLE == CMP_MULTIPLY) begin : g_mult
         localparam logic [PW-1:0] SEED_MAX = PW'({SEED_W{1'b1}});
         localparam logic [PW-1:0] MANT_MAX = PW'({SRC_MANT_W{1'b1}});
         assign lhs = disc_ext * SEED_MAX;
         assign rhs = draw_ext * MANT_MAX;
      end else begin : g_shsub
         // x * (2^k - 1) == (x << k) - x
         assign lhs = (disc_ext << SEED_W) - disc_ext;
         assign rhs = (draw_ext << SRC_MANT_W) - draw_ext;
      end
   endgenerate

   assign take_up = (lhs <= rhs);

endmodule

// File: rtl/sr_mant_inc.sv
module sr_mant_inc #(
   parameter int unsigned DST_MANT_W = 7,
   parameter int unsigned DST_EXP_W  = 8
) (
   input  logic                  bump,
   input  logic [DST_EXP_W-1:0]  exp_i,
   input  logic [DST_MANT_W-1:0] mant_i,
   output logic [DST_EXP_W-1:0]  exp_o,
   output logic [DST_MANT_W-1:0] mant_o
);

   localparam logic [DST_MANT_W-1:0] MANT_FULL = {DST_MANT_W{1'b1}};
   localparam logic [DST_EXP_W-1:0]  EXP_FULL  = {DST_EXP_W{1'b1}};

   logic mant_wraps;
   logic exp_sat;

   assign mant_wraps = (mant_i == MANT_FULL);
   assign exp_sat    = (exp_i == EXP_FULL);

   always_comb begin
      exp_o  = exp_i;
      mant_o = mant_i;
      if (bump) begin
         if (mant_wraps) begin
            mant_o = '0;
            if (!exp_sat) begin
               exp_o = exp_i + 1'b1;
            end
         end else begin
            mant_o = mant_i + 1'b1;
         end
      end
   end

endmodule

// File: rtl/sr_round_stage.sv
module sr_round_stage
   import sr_round_pkg::*;
#(
   parameter int unsigned SRC_MANT_W = 23,
   parameter int unsigned DST_MANT_W = 7,
   parameter int unsigned DST_EXP_W  = 8,
   parameter int unsigned SEED_W     = 32,
   parameter cmp_style_e  CMP_STYLE  = CMP_SHIFT_SUB,
   localparam int unsigned DISC_W    = SRC_MANT_W - DST_MANT_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic                  in_sign,
   input  logic [DST_EXP_W-1:0]  in_exp,
   input  logic [DST_MANT_W-1:0] in_mant,
   input  logic [DISC_W-1:0]     in_disc,
   input  logic [SEED_W-1:0]     in_seed,
   output logic                  out_valid,
   output logic                  out_sign,
   output logic [DST_EXP_W-1:0]  out_exp,
   output logic [DST_MANT_W-1:0] out_mant
);

   // Elaboration-time parameter checks.
   generate
      if (SRC_MANT_W <= DST_MANT_W) begin : g_bad_narrow
         $error("sr_round_stage: source mantissa must be wider than destination");
      end
      if (SEED_W < MIN_SEED_W) begin : g_bad_seed
         $error("sr_round_stage: seed width too small for feedback taps");
      end
      if (DST_EXP_W < 1 || DST_MANT_W < 1) begin : g_bad_dst
         $error("sr_round_stage: destination fields must be non-empty");
      end
   endgenerate

   logic [SEED_W-1:0]     draw;
   logic                  round_up;
   logic [DST_EXP_W-1:0]  exp_next;
   logic [DST_MANT_W-1:0] mant_next;

   sr_draw_gen #(
      .SEED_W (SEED_W)
   ) u_draw (
      .seed (in_seed),
      .draw (draw)
   );

   sr_frac_cmp #(
      .DISC_W     (DISC_W),
      .SRC_MANT_W (SRC_MANT_W),
      .SEED_W     (SEED_W),
      .CMP_STYLE  (CMP_STYLE)
   ) u_cmp (
      .disc    (in_disc),
      .draw    (draw),
      .take_up (round_up)
   );

   sr_mant_inc #(
      .DST_MANT_W (DST_MANT_W),
      .DST_EXP_W  (DST_EXP_W)
   ) u_inc (
      .bump   (round_up),
      .exp_i  (in_exp),
      .mant_i (in_mant),
      .exp_o  (exp_next),
      .mant_o (mant_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sign  <= 1'b0;
         out_exp   <= '0;
         out_mant  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_sign <= in_sign;
            out_exp  <= exp_next;
            out_mant <= mant_next;
         end
      end
   end

endmodule

// File: rtl/sr_round_checker.sv
module sr_round_checker #(
   parameter int unsigned DST_MANT_W = 7,
   parameter int unsigned DST_EXP_W  = 8,
   parameter int unsigned DISC_W     = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  in_valid,
   input logic                  in_sign,
   input logic [DST_EXP_W-1:0]  in_exp,
   input logic [DST_MANT_W-1:0] in_mant,
   input logic [DISC_W-1:0]     in_disc,
   input logic                  out_valid,
   input logic                  out_sign,
   input logic [DST_EXP_W-1:0]  out_exp,
   input logic [DST_MANT_W-1:0] out_mant
);

   localparam logic [DST_MANT_W-1:0] MFULL = {DST_MANT_W{1'b1}};
   localparam logic [DST_EXP_W-1:0]  EFULL = {DST_EXP_W{1'b1}};

   // R2
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_mant) && $stable(out_exp) && $stable(out_sign)));
   // R9
   a_r9_sign: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_sign == $past(in_sign)));
   // R5, R6: exponent untouched unless the mantissa can wrap
   a_r6_exp_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mant != MFULL) |=> (out_exp == $past(in_exp)));
   // R7: an all-ones mantissa either stays or wraps to zero
   a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mant == MFULL) |=> (out_mant == '0 || out_mant == MFULL));
   // R8
   a_r8_exp_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_exp == EFULL) |=> (out_exp == EFULL));
   // R10
   a_r10_zero_disc: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_disc == '0) |=> (out_mant == DST_MANT_W'($past(in_mant) + 1'b1)));

endmodule

bind sr_round_stage sr_round_checker #(
   .DST_MANT_W (DST_MANT_W),
   .DST_EXP_W  (DST_EXP_W),
   .DISC_W     (DISC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sign   (in_sign),
   .in_exp    (in_exp),
   .in_mant   (in_mant),
   .in_disc   (in_disc),
   .out_valid (out_valid),
   .out_sign  (out_sign),
   .out_exp   (out_exp),
   .out_mant  (out_mant)
);

// File: tb/sim_sr_round_stage.sv
`timescale 1ns/1ps
module sim_sr_round_stage;

   localparam int unsigned SRC_MANT_W = 23;
   localparam int unsigned DST_MANT_W = 7;
   localparam int unsigned DST_EXP_W  = 8;
   localparam int unsigned SEED_W     = 32;
   localparam int unsigned DISC_W     = SRC_MANT_W - DST_MANT_W;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic                  in_sign = 1'b0;
   logic [DST_EXP_W-1:0]  in_exp = '0;
   logic [DST_MANT_W-1:0] in_mant = '0;
   logic [DISC_W-1:0]     in_disc = '0;
   logic [SEED_W-1:0]     in_seed = '0;
   logic                  out_valid;
   logic                  out_sign;
   logic [DST_EXP_W-1:0]  out_exp;
   logic [DST_MANT_W-1:0] out_mant;

   always #2 clk = ~clk;   // 250 MHz

   sr_round_stage #(
      .SRC_MANT_W (SRC_MANT_W),
      .DST_MANT_W (DST_MANT_W),
      .DST_EXP_W  (DST_EXP_W),
      .SEED_W     (SEED_W)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_sign (in_sign),
      .in_exp (in_exp), .in_mant (in_mant), .in_disc (in_disc), .in_seed (in_seed),
      .out_valid (out_valid), .out_sign (out_sign), .out_exp (out_exp), .out_mant (out_mant)
   );

   typedef struct {
      logic                  s;
      logic [DST_EXP_W-1:0]  e;
      logic [DST_MANT_W-1:0] m;
      string                 tag;
   } item_t;

   item_t q[$];
   item_t last;
   int n_cmp = 0;
   int n_bad = 0;
   bit have_last = 0;

   function automatic item_t model(logic s, logic [7:0] e, logic [6:0] m,
                                   logic [15:0] d, logic [31:0] sd, string tag);
      item_t r;
      logic fb;
      logic [31:0] draw;
      logic [63:0] lhs, rhs;
      fb   = sd[0] ^ sd[1] ^ sd[3] ^ sd[12];
      draw = (sd >> 1) | ({31'd0, fb} << 15);
      lhs  = 64'(d) * 64'hFFFF_FFFF;
      rhs  = 64'(draw) * 64'h7F_FFFF;
      r.s = s; r.e = e; r.m = m; r.tag = tag;
      if (lhs <= rhs) begin
         if (m == 7'h7F) begin
            r.m = '0;
            if (e != 8'hFF) r.e = e + 1'b1;
         end else begin
            r.m = m + 1'b1;
         end
      end
      return r;
   endfunction

   task automatic check(string tag, string what, int act, int expv);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic drive(logic s, logic [7:0] e, logic [6:0] m, logic [15:0] d,
                        logic [31:0] sd, string tag);
      @(negedge clk);
      in_valid = 1'b1; in_sign = s; in_exp = e; in_mant = m; in_disc = d; in_seed = sd;
      q.push_back(model(s, e, m, d, sd, tag));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_seed = $urandom;
         in_disc = 16'($urandom);
         in_mant = 7'($urandom);
      end
   endtask

   // Monitor: compares each result against the head of the scoreboard.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            check("R2", "unexpected out_valid", 1, 0);
         end else begin
            item_t x;
            x = q.pop_front();
            check(x.tag, "mant", int'(out_mant), int'(x.m));
            check(x.tag, "exp", int'(out_exp), int'(x.e));
            check("R9", "sign", int'(out_sign), int'(x.s));
            last = x;
            have_last = 1;
         end
      end
   end

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #800000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "out_valid in reset", int'(out_valid), 0);
      check("R1", "out_mant in reset", int'(out_mant), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "out_valid after reset", int'(out_valid), 0);
      check("R1", "out_exp after reset", int'(out_exp), 0);
      check("R1", "out_sign after reset", int'(out_sign), 0);

      // R5: large discard, seed 0 -> draw 0 -> no round-up
      drive(1'b0, 8'h40, 7'h12, 16'hFFFF, 32'h0, "R5");
      // R6: small discard, big draw -> +1
      drive(1'b0, 8'h40, 7'h12, 16'h0001, 32'hFFFF_FFFF, "R6");
      // R3: seed 1 gives draw 0x8000 only via the feedback bit; disc 63 rounds up
      drive(1'b0, 8'h22, 7'h20, 16'd63, 32'h1, "R3");
      // R3: seed bit 12 alone feeds back: draw 0x8800
      drive(1'b1, 8'h22, 7'h30, 16'd66, 32'h1000, "R3");
      // R4: threshold: disc 64 with draw 0x8000 does not round, draw 0x8001 does
      drive(1'b0, 8'h22, 7'h20, 16'd64, 32'h1, "R4");
      drive(1'b0, 8'h22, 7'h20, 16'd64, 32'h2, "R4");
      // R7: wrap into exponent
      drive(1'b0, 8'h10, 7'h7F, 16'h0, 32'h0, "R7");
      // R8: saturated exponent
      drive(1'b1, 8'hFF, 7'h7F, 16'h0, 32'h5A5A_0000, "R8");
      // R10: zero discard with zero seed still rounds up
      drive(1'b1, 8'h01, 7'h55, 16'h0, 32'h0, "R10");
      // R5: all-ones mantissa not rounded stays all ones
      drive(1'b0, 8'h10, 7'h7F, 16'hFFFF, 32'h0, "R5");
      idle(1);
      @(negedge clk);
      // R2: idle cycles with changing inputs leave results unchanged
      idle(3);
      @(negedge clk);
      check("R2", "out_valid idle", int'(out_valid), 0);
      check("R2", "mant held", int'(out_mant), have_last ? int'(last.m) : -1);
      check("R2", "exp held", int'(out_exp), have_last ? int'(last.e) : -1);

      // R4: random traffic, with gaps
      for (int i = 0; i < 400; i++) begin
         logic [15:0] d;
         d = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 80)) : 16'($urandom);
         drive(1'($urandom), 8'($urandom), 7'($urandom), d, $urandom, "R4");
         if ($urandom_range(0, 4) == 0) idle(1);
      end
      idle(3);
      check("R2", "scoreboard drained", q.size(), 0);
      finish_run();
   end

endmodule